// File: doc/BRIEF.md
# Shared-Memory Reservation Tracker

This block sits in front of a small shared memory used by several processors and gives them lock-free atomic update. A processor first issues a reserving load. The load returns the word and marks that processor as holding a reservation on that address. Later the processor issues a conditional store. The store is written only if the reservation is still intact, and the response says whether it was written. A retry loop around this pair builds atomic read-modify-write sequences such as counters and queue pointers without a lock.

Every processor presents one request at a time: a valid bit, an operation code, an address and write data. A fixed-priority arbiter serves one request per clock cycle, lowest index first. A processor keeps its request asserted until its grant bit rises. The response arrives on the following cycle. Any store that reaches memory, whether a plain store or a successful conditional one, cancels the reservations that other processors hold on that word. This stands in for a coherence invalidation. A build parameter selects a lighter variant that keeps only a flag per processor, with no address. In that variant any store from another processor clears the flag. The variant is only sound when reservations are never nested.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no response is valid, every memory word reads zero and no processor holds a reservation, so a conditional store issued first fails.
- R2: Each cycle at most one grant bit is high. It is the lowest-index processor whose request is valid, and it rises in the same cycle as that request.
- R3: The response for a grant appears on the next cycle: the granted processor's bit of the response-valid vector, the memory word at the request address as it was before that cycle's write, and a status bit.
- R4: A reserving load (operation code 2) returns the word and records a reservation for that processor on that address. Status is 1.
- R5: A conditional store (operation code 3) succeeds when its processor holds a reservation whose address equals the store address. It then writes the word and returns status 1.
- R6: A conditional store without a matching reservation returns status 0 and leaves memory unchanged.
- R7: A conditional store clears its own processor's reservation whether it succeeds or fails, so an immediate second one fails.
- R8: A write by a plain store (operation code 1) or by a successful conditional store cancels reservations held by other processors on the same address. Reservations on other addresses are kept.
- R9: A plain store always writes and returns status 1, and leaves its own processor's reservation intact. A plain load (operation code 0) returns the word with status 1.
- R10: With address tracking disabled, a conditional store succeeds whenever its processor's flag is set, whatever the address. Any write from another processor clears the flag, whatever the address.
- R11: Processors running concurrent increment loops of reserving load and conditional store against one word end with that word equal to the total number of increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | NUM_PROC | Request pending, one bit per processor |
| reqOp | input | 2*NUM_PROC | Operation code per processor (0 load, 1 store, 2 reserving load, 3 conditional store) |
| reqAddr | input | ADDR_W*NUM_PROC | Word address per processor |
| reqWdata | input | DATA_W*NUM_PROC | Write data per processor |
| grant | output | NUM_PROC | One-hot request accepted this cycle |
| respValid | output | NUM_PROC | Response valid for that processor |
| respData | output | DATA_W | Memory word read for the served request |
| respOk | output | 1 | Status: 0 only for a failed conditional store |

## Verification
Two things can meet in one cycle. One is a processor's conditional store waiting behind a higher-priority request. The other is the invalidation that this higher-priority request causes. The bench raises a plain store from processor 0 and a conditional store from processor 1 to the same reserved word in the same cycle. It checks that the store is served first and the conditional store fails on the cycle after. Random single requests over four addresses and the contended increment loops hit the same overlap many more times, and a bench reference model judges every response.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LRSV  = 2'd2,
    OP_SCOND = 2'd3
  } memOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic memWrite;
    logic respOk;
  } dpStrobe_t;
endpackage

// File: rtl/rsv_arbiter.sv
module rsv_arbiter #(
  parameter int NUM_PROC = 4,
  parameter int IDX_W    = 2
) (
  input  logic [NUM_PROC-1:0] reqValid,
  output logic [NUM_PROC-1:0] grant,
  output logic [IDX_W-1:0]    grantIdx,
  output logic                anyGrant
);
  always_comb begin
    grant    = '0;
    grantIdx = '0;
    anyGrant = 1'b0;
    for (int i = 0; i < NUM_PROC; i++) begin
      if (reqValid[i] && !anyGrant) begin
        grant[i] = 1'b1;
        grantIdx = IDX_W'(i);
        anyGrant = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsv_control.sv
module rsv_control
  import rsv_pkg::*;
#(
  parameter int NUM_PROC   = 4,
  parameter int ADDR_W     = 4,
  parameter bit TRACK_ADDR = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                anyGrant,
  input  logic [NUM_PROC-1:0] grant,
  input  memOp_t              selOp,
  input  logic [ADDR_W-1:0]   selAddr,
  output dpStrobe_t           strobe
);
  logic [NUM_PROC-1:0] rsvFlag;
  logic [NUM_PROC-1:0] addrMatch;
  logic scPass;
  logic isWrite;

  generate
    if (TRACK_ADDR) begin : gen_track
      logic [ADDR_W-1:0] rsvAddr [NUM_PROC];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int g = 0; g < NUM_PROC; g++) rsvAddr[g] <= '0;
        end else if (anyGrant && selOp == OP_LRSV) begin
          for (int g = 0; g < NUM_PROC; g++)
            if (grant[g]) rsvAddr[g] <= selAddr;
        end
      end
      always_comb begin
        for (int g = 0; g < NUM_PROC; g++) addrMatch[g] = (rsvAddr[g] == selAddr);
      end
    end else begin : gen_flag
      assign addrMatch = '1;
    end
  endgenerate

  assign scPass  = |(grant & rsvFlag & addrMatch);
  assign isWrite = anyGrant && (selOp == OP_STORE || (selOp == OP_SCOND && scPass));

  always_comb begin
    strobe.memWrite = isWrite;
    strobe.respOk   = (selOp != OP_SCOND) || scPass;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsvFlag <= '0;
    end else if (anyGrant) begin
      for (int g = 0; g < NUM_PROC; g++) begin
        if (grant[g]) begin
          if (selOp == OP_LRSV)       rsvFlag[g] <= 1'b1;
          else if (selOp == OP_SCOND) rsvFlag[g] <= 1'b0;
        end else if (isWrite && addrMatch[g]) begin
          rsvFlag[g] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rsv_datapath.sv
module rsv_datapath
  import rsv_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [2*NUM_PROC-1:0]      reqOp,
  input  logic [ADDR_W*NUM_PROC-1:0] reqAddr,
  input  logic [DATA_W*NUM_PROC-1:0] reqWdata,
  input  logic [NUM_PROC-1:0]        grant,
  input  logic                       anyGrant,
  input  logic [IDX_W-1:0]           grantIdx,
  input  dpStrobe_t                  strobe,
  output memOp_t                     selOp,
  output logic [ADDR_W-1:0]          selAddr,
  output logic [NUM_PROC-1:0]        respValid,
  output logic [DATA_W-1:0]          respData,
  output logic                       respOk
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memWord [DEPTH];
  logic [DATA_W-1:0] selData;

  assign selOp   = memOp_t'(reqOp[grantIdx*2 +: 2]);
  assign selAddr = reqAddr[grantIdx*ADDR_W +: ADDR_W];
  assign selData = reqWdata[grantIdx*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) memWord[w] <= '0;
    end else if (strobe.memWrite) begin
      memWord[selAddr] <= selData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= '0;
      respData  <= '0;
      respOk    <= 1'b0;
    end else begin
      respValid <= grant;
      if (anyGrant) begin
        respData <= memWord[selAddr];
        respOk   <= strobe.respOk;
      end
    end
  end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int NUM_PROC   = 4,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter bit TRACK_ADDR = 1'b1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PROC-1:0]        reqValid,
  input  logic [2*NUM_PROC-1:0]      reqOp,
  input  logic [ADDR_W*NUM_PROC-1:0] reqAddr,
  input  logic [DATA_W*NUM_PROC-1:0] reqWdata,
  output logic [NUM_PROC-1:0]        grant,
  output logic [NUM_PROC-1:0]        respValid,
  output logic [DATA_W-1:0]          respData,
  output logic                       respOk
);
  localparam int IDX_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1;

  logic [IDX_W-1:0]  grantIdx;
  logic              anyGrant;
  memOp_t            selOp;
  logic [ADDR_W-1:0] selAddr;
  dpStrobe_t         strobe;

  rsv_arbiter #(.NUM_PROC(NUM_PROC), .IDX_W(IDX_W)) i_arb (
    .reqValid(reqValid), .grant(grant), .grantIdx(grantIdx), .anyGrant(anyGrant)
  );

  rsv_control #(.NUM_PROC(NUM_PROC), .ADDR_W(ADDR_W), .TRACK_ADDR(TRACK_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .anyGrant(anyGrant), .grant(grant),
    .selOp(selOp), .selAddr(selAddr), .strobe(strobe)
  );

  rsv_datapath #(.NUM_PROC(NUM_PROC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .reqOp(reqOp), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .grant(grant), .anyGrant(anyGrant), .grantIdx(grantIdx), .strobe(strobe),
    .selOp(selOp), .selAddr(selAddr), .respValid(respValid),
    .respData(respData), .respOk(respOk)
  );
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
  parameter int NUM_PROC = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PROC-1:0] reqValid,
  input logic [NUM_PROC-1:0] grant,
  input logic [NUM_PROC-1:0] respValid
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~reqValid) == '0);

  assert_grant_top_priority_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid[0] |-> grant[0]);

  assert_grant_when_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |-> (|grant));

  assert_resp_follows_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |=> (respValid == $past(grant)));

  assert_resp_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(respValid));
endmodule

bind rsv_monitor rsv_monitor_chk #(.NUM_PROC(NUM_PROC)) i_rsvChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .grant(grant), .respValid(respValid)
);

// File: tb/test_rsv_monitor.sv
module test_rsv_monitor;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int ITER = 20;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LR = 2'd2, SC = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]    reqValid = '0;
  logic [2*NP-1:0]  reqOp = '0;
  logic [AW*NP-1:0] reqAddr = '0;
  logic [DW*NP-1:0] reqWdata = '0;
  logic [NP-1:0] gA, rvA, gB, rvB;
  logic [DW-1:0] rdA, rdB;
  logic rokA, rokB;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] refMem [16];
  logic          refFlag [NP];
  logic [AW-1:0] refAdr [NP];

  always #5 clk = ~clk;

  rsv_monitor #(.NUM_PROC(NP), .ADDR_W(AW), .DATA_W(DW), .TRACK_ADDR(1'b1)) i_rsv_monitor (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .grant(gA), .respValid(rvA), .respData(rdA), .respOk(rokA)
  );

  rsv_monitor #(.NUM_PROC(NP), .ADDR_W(AW), .DATA_W(DW), .TRACK_ADDR(1'b0)) i_rsv_monitor_flag (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .grant(gB), .respValid(rvB), .respData(rdB), .respOk(rokB)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [NP-1:0] lowBit(logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return NP'(1) << i;
    return '0;
  endfunction

  task automatic modelExec(int p, logic [1:0] op, int a, logic [DW-1:0] d,
                           output logic [DW-1:0] ed, output logic eo);
    logic wr;
    ed = refMem[a];
    eo = 1'b1;
    wr = 1'b0;
    case (op)
      LR: begin refFlag[p] = 1'b1; refAdr[p] = AW'(a); end
      SC: begin
        eo = refFlag[p] && (refAdr[p] == AW'(a));
        refFlag[p] = 1'b0;
        wr = eo;
      end
      ST: wr = 1'b1;
      default: ;
    endcase
    if (wr) begin
      refMem[a] = d;
      for (int q = 0; q < NP; q++)
        if (q != p && refFlag[q] && refAdr[q] == AW'(a)) refFlag[q] = 1'b0;
    end
  endtask

  task automatic setReq(int p, logic [1:0] op, int a, logic [DW-1:0] d);
    reqValid[p] = 1'b1;
    reqOp[p*2 +: 2] = op;
    reqAddr[p*AW +: AW] = AW'(a);
    reqWdata[p*DW +: DW] = d;
  endtask

  // one request alone; returns after the response is visible
  task automatic doOp(int p, logic [1:0] op, int a, logic [DW-1:0] d, string tag);
    logic [DW-1:0] ed;
    logic eo;
    modelExec(p, op, a, d, ed, eo);
    reqValid = '0;
    setReq(p, op, a, d);
    #1;
    chk({tag, " R2 grant"}, 32'(gA), 32'(NP'(1) << p));
    @(negedge clk);
    reqValid = '0;
    chk({tag, " R3 respValid"}, 32'(rvA), 32'(NP'(1) << p));
    chk({tag, " data"}, 32'(rdA), 32'(ed));
    chk({tag, " status"}, 32'(rokA), 32'(eo));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int st [NP];
    logic [DW-1:0] seen [NP];
    int wins [NP];
    int cyc;
    bit allDone;
    logic [DW-1:0] ed;
    logic eo;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 16; i++) refMem[i] = '0;
    for (int i = 0; i < NP; i++) begin refFlag[i] = 1'b0; refAdr[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 respValid after reset", 32'(rvA), 0);
    chk("R1 respData after reset", 32'(rdA), 0);
    rstN = 1'b1;
    @(negedge clk);

    doOp(0, SC, 3, 16'h0005, "R1 R6 first conditional store fails");
    chk("R1 flag mode first conditional store fails", 32'(rokB), 0);
    doOp(1, LD, 3, 0, "R6 R9 word untouched after failed store");
    doOp(2, ST, 3, 16'h0007, "R9 plain store");
    doOp(0, LR, 3, 0, "R4 reserving load returns word");
    doOp(0, SC, 3, 16'h0008, "R5 conditional store succeeds");
    doOp(0, SC, 3, 16'h0009, "R7 second conditional store fails");
    doOp(1, LD, 3, 0, "R5 R7 word holds first write");

    doOp(1, LR, 4, 0, "R4 reserve addr 4");
    doOp(2, LR, 5, 0, "R4 reserve addr 5");
    doOp(0, ST, 4, 16'h0011, "R8 other store to addr 4");
    doOp(1, SC, 4, 16'h0022, "R8 cancelled reservation fails");
    doOp(2, SC, 5, 16'h0033, "R8 other-address reservation kept");
    chk("R10 flag mode cleared by store elsewhere", 32'(rokB), 0);

    doOp(3, LR, 6, 0, "R4 reserve addr 6");
    doOp(3, ST, 6, 16'h0002, "R9 own plain store");
    doOp(3, SC, 6, 16'h0003, "R9 own reservation survives own store");

    doOp(1, LR, 2, 0, "R4 reserve addr 2");
    doOp(1, SC, 9, 16'h0055, "R5 R6 address mismatch fails");
    chk("R10 flag mode ignores address", 32'(rokB), 1);
    doOp(1, LD, 9, 0, "R6 mismatch left memory");
    chk("R10 flag mode wrote word 9", 32'(rdB), 32'h55);

    // same-cycle: store from 0 and conditional store from 1 on the reserved word
    doOp(1, LR, 10, 0, "R4 reserve addr 10");
    modelExec(0, ST, 10, 16'h0aaa, ed, eo);
    modelExec(1, SC, 10, 16'h0bbb, ed, eo);
    reqValid = '0;
    setReq(0, ST, 10, 16'h0aaa);
    setReq(1, SC, 10, 16'h0bbb);
    #1;
    chk("R2 lower index served first", 32'(gA), 1);
    @(negedge clk);
    reqValid[0] = 1'b0;
    chk("R3 store response", 32'(rvA), 1);
    #1;
    chk("R2 waiting request served next", 32'(gA), 2);
    @(negedge clk);
    reqValid = '0;
    chk("R8 waiting conditional store fails", 32'(rokA), 32'(eo));
    chk("R8 expected failure", 32'(eo), 0);
    doOp(2, LD, 10, 0, "R8 word holds plain store");

    // constrained random single requests over a small address window
    for (int n = 0; n < 400; n++) begin
      int p;
      int a;
      p = int'($urandom % NP);
      a = int'($urandom % 4);
      doOp(p, 2'($urandom % 4), a, 16'($urandom), "R4 R5 R6 R7 R8 R9 random");
    end

    // concurrent increment loops on word 15
    for (int p = 0; p < NP; p++) begin st[p] = 0; wins[p] = 0; seen[p] = '0; end
    cyc = 0;
    allDone = 1'b0;
    while (!allDone && cyc < 20000) begin
      cyc++;
      for (int p = 0; p < NP; p++) begin
        if (rvA[p]) begin
          if (st[p] == 1) begin
            seen[p] = rdA;
            st[p] = 2;
          end else if (st[p] == 3) begin
            if (rokA) begin
              wins[p]++;
              st[p] = (wins[p] == ITER) ? 4 : 0;
            end else begin
              st[p] = 0;
            end
          end
        end
      end
      allDone = 1'b1;
      for (int p = 0; p < NP; p++) if (st[p] != 4) allDone = 1'b0;
      reqValid = '0;
      for (int p = 0; p < NP; p++) begin
        if (st[p] == 0 && ($urandom % 4 != 0)) setReq(p, LR, 15, 0);
        else if (st[p] == 2 && ($urandom % 4 != 0)) setReq(p, SC, 15, seen[p] + 16'd1);
      end
      #1;
      if (gA !== lowBit(reqValid)) chk("R2 loop grant priority", 32'(gA), 32'(lowBit(reqValid)));
      for (int p = 0; p < NP; p++) if (gA[p]) st[p] = st[p] + 1;
      @(negedge clk);
    end
    reqValid = '0;
    chk("R11 loops completed", 32'(allDone), 1);
    refMem[15] = 16'(NP * ITER);
    doOp(0, LD, 15, 0, "R11 final count exact");
    finishRun();
  end
endmodule